// File: doc/BRIEF.md
# Stepper Sweep Sequencer

This block drives one of four two-wire stepper channels back and forth on its own. Each channel owns a direction bit and a step bit inside a shared control byte. A host sets the step delay and the step count for each direction, picks a channel and pulses start. The block then runs a right run and a left run in turn, and repeats that cycle until a stop request arrives.

In a right run the block clears the selected direction bit. In a left run it sets that bit. Each step toggles the channel's step bit, waits one delay, toggles the bit back and waits one more delay. The delay is counted in pulses of a clock-enable input.

The bits of the other channels are never touched while a sweep runs. The host can write the whole byte only while the block is idle. All interfaces are plain control pins. No data stream crosses the block's edge, so there is no back-pressure and no valid/ready handshake.

Top module: `stepper_sweep`

## Requirements
- R1: After reset the control byte is 0x00 and busy is low. The delay register resets to 0x100 and both step counts reset to 200, so a step's first half lasts 257 clocks when tick is high in every cycle.
- R2: Channel n (1..4) uses bit 2(n-1) of the byte as its direction bit and bit 2(n-1)+1 as its step bit. A select value of 0 is clamped to channel 1, and any value above 4 is clamped to channel 4.
- R3: A start pulse while idle makes busy high one clock later. A start pulse while busy is ignored, including any new select value that comes with it.
- R4: A right run clears the direction bit and makes exactly right-count steps. A left run then sets the direction bit and makes exactly left-count steps. The two runs alternate for as long as the block is busy.
- R5: A step is made of a toggle, a wait, a toggle back and a second wait. Each wait counts `delay` tick pulses. With tick high in every cycle, the toggled level lasts delay+1 clocks, and delay+2 clocks pass from the toggle back to the first toggle of the next step.
- R6: While busy, only the selected channel's two bits may change, and at most one bit changes per clock.
- R7: A stop request, held or pulsed, lets the current step finish and ends the sweep before the next step begins. The step bit is left at its level from before that step, and busy falls. A stop request while idle has no effect on the next sweep.
- R8: The delay and both step counts may be written at any time. A run uses the values present when that run begins, so a write during a run affects only later runs.
- R9: A host byte write takes effect only while the block is idle. While busy it is ignored, and the byte holds its value when the block is idle and nothing writes it.
- R10: A run with a step count of zero sets or clears the direction bit and passes straight to the next run without toggling the step bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| tick | input | 1 | Clock enable that sets the delay unit |
| start | input | 1 | Begin a sweep when idle |
| stop_req | input | 1 | Request to end the sweep before the next step |
| motor_sel | input | 3 | Channel select 1..4, clamped |
| cfg_wr | input | 1 | Load the delay and step-count registers |
| cfg_delay | input | 16 | Delay in tick pulses |
| cfg_right_len | input | 16 | Steps per right run |
| cfg_left_len | input | 16 | Steps per left run |
| host_wr | input | 1 | Write the whole control byte (idle only) |
| host_wdata | input | 8 | Byte value to write |
| ctrl_byte | output | 8 | Direction and step bits of all channels |
| busy | output | 1 | High while a sweep is running |

## Verification
A table of sweeps varies the channel, the delay, the two step counts and the preset byte. It includes select values that need clamping, zero delay, zero-length runs in one or both directions, and presets of all ones, all zeros and mixed patterns. Counting step-bit toggles for each direction separates a wrong count or a wrong direction from a wrong bit position. The all-ones and mixed presets expose any disturbance of a neighbouring channel, and the intervals between toggles expose a wrong wait length. Directed tests cover the reset defaults, a configuration write during a run, stop during a step, and start or byte writes while busy.

// File: rtl/stepper_sweep_pkg.sv
package stepper_sweep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CHECK,
    ST_HALF_A,
    ST_HALF_B
  } sweep_state_e;
endpackage

// File: rtl/sweep_delay_timer.sv
module sweep_delay_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= load_val;
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sweep_step_fsm.sv
module sweep_step_fsm
  import stepper_sweep_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int CNT_W = 16,
  parameter int CH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop_req,
  input  logic [CH_W-1:0]  sel_idx,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic [CNT_W-1:0] rlen_cfg,
  input  logic [CNT_W-1:0] llen_cfg,
  input  logic             timer_expired,
  output logic             busy,
  output logic [CH_W-1:0]  chan_q,
  output logic             dir_we,
  output logic             dir_val,
  output logic             step_tgl,
  output logic             timer_load,
  output logic [DLY_W-1:0] timer_val
);
  sweep_state_e     state_q, state_d;
  logic             dir_left_q;
  logic             stop_pend_q;
  logic [CNT_W-1:0] remain_q;
  logic [DLY_W-1:0] dly_q;
  logic             abort;

  assign abort     = stop_req | stop_pend_q;
  assign busy      = (state_q != ST_IDLE);
  assign timer_val = dly_q;
  assign dir_val   = dir_left_q;

  always_comb begin
    state_d    = state_q;
    dir_we     = 1'b0;
    step_tgl   = 1'b0;
    timer_load = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_SETUP;
      ST_SETUP: begin
        dir_we  = 1'b1;
        state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (abort)                 state_d = ST_IDLE;
        else if (remain_q == '0)   state_d = ST_SETUP;
        else begin
          step_tgl   = 1'b1;
          timer_load = 1'b1;
          state_d    = ST_HALF_A;
        end
      end
      ST_HALF_A: if (timer_expired) begin
        step_tgl   = 1'b1;
        timer_load = 1'b1;
        state_d    = ST_HALF_B;
      end
      ST_HALF_B: if (timer_expired) state_d = ST_CHECK;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      dir_left_q  <= 1'b0;
      stop_pend_q <= 1'b0;
      remain_q    <= '0;
      dly_q       <= '0;
      chan_q      <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        stop_pend_q <= 1'b0;
        if (start) begin
          chan_q     <= sel_idx;
          dir_left_q <= 1'b0;
        end
      end else if (state_q == ST_CHECK && abort) begin
        stop_pend_q <= 1'b0;
      end else if (stop_req) begin
        stop_pend_q <= 1'b1;
      end
      if (state_q == ST_SETUP) begin
        remain_q <= dir_left_q ? llen_cfg : rlen_cfg;
        dly_q    <= delay_cfg;
      end
      if (state_q == ST_CHECK && !abort) begin
        if (remain_q == '0) dir_left_q <= ~dir_left_q;
        else                remain_q   <= remain_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/stepper_sweep.sv
module stepper_sweep #(
  parameter int              CHANNELS      = 4,
  parameter int              SEL_W         = 3,
  parameter int              DLY_W         = 16,
  parameter int              CNT_W         = 16,
  parameter logic [15:0]     DLY_DEFAULT   = 16'h0100,
  parameter logic [15:0]     SWING_DEFAULT = 16'd200
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  start,
  input  logic                  stop_req,
  input  logic [SEL_W-1:0]      motor_sel,
  input  logic                  cfg_wr,
  input  logic [DLY_W-1:0]      cfg_delay,
  input  logic [CNT_W-1:0]      cfg_right_len,
  input  logic [CNT_W-1:0]      cfg_left_len,
  input  logic                  host_wr,
  input  logic [2*CHANNELS-1:0] host_wdata,
  output logic [2*CHANNELS-1:0] ctrl_byte,
  output logic                  busy
);
  localparam int BYTE_W = 2 * CHANNELS;
  localparam int CH_W   = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;

  logic [CH_W-1:0]  sel_idx, chan_q;
  logic [DLY_W-1:0] delay_q, timer_val;
  logic [CNT_W-1:0] rlen_q, llen_q;
  logic             dir_we, dir_val, step_tgl, timer_load, timer_expired;
  logic [1:0]       pair_q [CHANNELS];

  // Clamp the select value into 1..CHANNELS, then make it zero-based.
  always_comb begin
    if (motor_sel == '0)                          sel_idx = '0;
    else if (motor_sel >= SEL_W'(CHANNELS))       sel_idx = CH_W'(CHANNELS - 1);
    else                                          sel_idx = CH_W'(motor_sel - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_q <= DLY_W'(DLY_DEFAULT);
      rlen_q  <= CNT_W'(SWING_DEFAULT);
      llen_q  <= CNT_W'(SWING_DEFAULT);
    end else if (cfg_wr) begin
      delay_q <= cfg_delay;
      rlen_q  <= cfg_right_len;
      llen_q  <= cfg_left_len;
    end
  end

  sweep_step_fsm #(.DLY_W(DLY_W), .CNT_W(CNT_W), .CH_W(CH_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
    .sel_idx(sel_idx), .delay_cfg(delay_q), .rlen_cfg(rlen_q), .llen_cfg(llen_q),
    .timer_expired(timer_expired), .busy(busy), .chan_q(chan_q),
    .dir_we(dir_we), .dir_val(dir_val), .step_tgl(step_tgl),
    .timer_load(timer_load), .timer_val(timer_val)
  );

  sweep_delay_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val),
    .tick(tick), .expired(timer_expired)
  );

  // One direction/step pair per channel; bit 0 is direction, bit 1 is step.
  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pair_q[g] <= 2'b00;
      end else if (host_wr && !busy) begin
        pair_q[g] <= host_wdata[2*g +: 2];
      end else if (busy && chan_q == CH_W'(g)) begin
        if (dir_we)   pair_q[g][0] <= dir_val;
        if (step_tgl) pair_q[g][1] <= ~pair_q[g][1];
      end
    end
    assign ctrl_byte[2*g +: 2] = pair_q[g];
  end
endmodule

// File: rtl/stepper_sweep_chk.sv
module stepper_sweep_chk #(
  parameter int BYTE_W = 8,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start,
  input logic              host_wr,
  input logic [BYTE_W-1:0] ctrl_byte,
  input logic [CH_W-1:0]   chan_q
);
  logic [BYTE_W-1:0] own_mask;
  assign own_mask = BYTE_W'(2'b11) << (2 * chan_q);

  AST_OTHERS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> (((ctrl_byte ^ $past(ctrl_byte)) & ~own_mask) == '0)); // R6

  AST_ONE_BIT_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(ctrl_byte ^ $past(ctrl_byte)) <= 1)); // R6

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !host_wr |=> $stable(ctrl_byte)); // R9
endmodule

bind stepper_sweep stepper_sweep_chk #(.BYTE_W(BYTE_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(start),
  .host_wr(host_wr), .ctrl_byte(ctrl_byte), .chan_q(chan_q)
);

// File: tb/stepper_sweep_tb.sv
module stepper_sweep_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCASE = 7;
  // sel, delay, right, left, left written mid-run (-1 none), preset byte
  localparam int VEC [NCASE][6] = '{
    '{1, 3, 4, 2, -1, 8'h00},
    '{2, 0, 3, 3,  5, 8'hFF},
    '{3, 5, 2, 5, -1, 8'h5A},
    '{4, 1, 1, 0, -1, 8'hA5},
    '{0, 2, 2, 1, -1, 8'h3C},
    '{7, 0, 0, 2, -1, 8'hC3},
    '{3, 0, 0, 0, -1, 8'h81}
  };

  logic clk = 0, rst_n = 0, tick = 1, start = 0, stop_req = 0;
  logic [2:0] motor_sel = 3'd1;
  logic cfg_wr = 0, host_wr = 0;
  logic [15:0] cfg_delay = 0, cfg_right_len = 0, cfg_left_len = 0;
  logic [7:0] host_wdata = 0, ctrl_byte;
  logic busy;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stepper_sweep u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop_req(stop_req),
    .motor_sel(motor_sel), .cfg_wr(cfg_wr), .cfg_delay(cfg_delay),
    .cfg_right_len(cfg_right_len), .cfg_left_len(cfg_left_len),
    .host_wr(host_wr), .host_wdata(host_wdata), .ctrl_byte(ctrl_byte), .busy(busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int sel, input int d, input int rl, input int ll,
                          input int mid, input int pre);
    int e, dpos, spos, phase, rt, lt, n, exp_l;
    int tt [3];
    bit mid_done, others_bad;
    logic [7:0] pb, mask, cur;
    logic prev_st;
    e = (sel < 1) ? 1 : (sel > 4) ? 4 : sel;   // R2 clamp
    dpos = 2*(e-1); spos = dpos + 1;
    mask = 8'h03 << dpos;
    pb = pre[7:0];
    exp_l = (mid >= 0) ? mid : ll;
    @(negedge clk);
    host_wr = 1; host_wdata = pb; cfg_wr = 1;
    cfg_delay = 16'(d); cfg_right_len = 16'(rl); cfg_left_len = 16'(ll); motor_sel = 3'(sel);
    @(negedge clk);
    host_wr = 0; cfg_wr = 0; start = 1;
    @(negedge clk);
    start = 0;
    check(busy === 1'b1, "R3 busy after start", int'(busy), 1);
    @(negedge clk);
    phase = 0; rt = 0; lt = 0; n = 0; mid_done = 0; others_bad = 0;
    prev_st = pb[spos];
    for (int k = 0; k < 5000 && phase < 2; k++) begin
      cur = ctrl_byte;
      if ((cur & ~mask) != (pb & ~mask)) others_bad = 1;
      cfg_wr = 0;
      if (cur[spos] != prev_st) begin
        if (phase == 0) begin
          rt++;
          if (n < 3) begin tt[n] = k; n++; end
          if (mid >= 0 && !mid_done) begin
            cfg_wr = 1; cfg_right_len = 16'd1; cfg_left_len = 16'(mid); mid_done = 1;
          end
        end else lt++;
      end
      prev_st = cur[spos];
      if (phase == 0 && cur[dpos]) phase = 1;
      else if (phase == 1 && !cur[dpos]) begin stop_req = 1; phase = 2; end
      @(negedge clk);
    end
    stop_req = 0; cfg_wr = 0;
    cur = ctrl_byte;
    check(rt == 2*rl, "R4/R10 right-run toggles", rt, 2*rl);
    check(lt == 2*exp_l, "R4/R8/R10 left-run toggles", lt, 2*exp_l);
    check(busy === 1'b0, "R7 busy after stop", int'(busy), 0);
    check(cur[spos] == pb[spos], "R7 step bit level", int'(cur[spos]), int'(pb[spos]));
    check(cur[dpos] == 1'b0, "R2/R4 direction bit after right start", int'(cur[dpos]), 0);
    check(!others_bad && (cur & ~mask) == (pb & ~mask), "R6 other channels",
          int'(cur), int'(pb));
    if (rl >= 2) begin
      check(tt[1]-tt[0] == d+1, "R5 first half", tt[1]-tt[0], d+1);
      check(tt[2]-tt[1] == d+2, "R5 second half", tt[2]-tt[1], d+2);
    end
  endtask

  initial begin
    int t0, w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ctrl_byte === 8'h00, "R1 reset byte", int'(ctrl_byte), 0);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);

    // R1 defaults: channel 1, no config write since reset.
    motor_sel = 3'd1; start = 1;
    @(negedge clk); start = 0;
    t0 = 0; w = 0;
    while (ctrl_byte[1] == 1'b0 && w < 100) begin @(negedge clk); w++; end
    for (int k = 0; k < 1000; k++) begin
      if (k == 10) begin
        // R3 start with another channel and R9 byte write, both while busy
        start = 1; motor_sel = 3'd2; host_wr = 1; host_wdata = 8'hFF;
      end else begin
        start = 0; host_wr = 0;
      end
      @(negedge clk);
      if (ctrl_byte[1] == 1'b0) begin t0 = k + 1; break; end
    end
    check(t0 == 257, "R1/R5 default delay width", t0, 257);
    stop_req = 1;
    @(negedge clk); stop_req = 0;
    w = 0;
    while (busy && w < 1000) begin @(negedge clk); w++; end
    check(busy === 1'b0, "R7 stop ends default sweep", int'(busy), 0);
    check(ctrl_byte === 8'h00, "R3/R9/R7 byte after busy-time writes", int'(ctrl_byte), 0);

    // R7 stop while idle must not abort the next sweep.
    stop_req = 1; @(negedge clk); stop_req = 0;

    for (int i = 0; i < NCASE; i++)
      run_case(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5]);

    // R9 idle byte write takes effect.
    @(negedge clk); host_wr = 1; host_wdata = 8'h69;
    @(negedge clk); host_wr = 0;
    check(ctrl_byte === 8'h69, "R9 idle write", int'(ctrl_byte), 8'h69);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule